// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block is an SPI master that takes a slave-configurable FPGA through a complete programming session without software in the loop. After `start_i` it opens the configuration session and checks the four-byte answer. It then switches the device into program mode and sends the bitstream as a series of fixed 16-byte frames. To finish, it closes the session, waits a settle time and releases the device. A two-read status poll gates every command, and each poll must see the busy flag clear before the command goes out.

The bitstream arrives as a byte stream with a valid/ready handshake. The frame count is sampled when the session starts. `done_o` stays high once the session has ended. When `error_o` is also high, `err_phase_o` and `err_kind_o` give the phase that failed and the cause. The SPI clock divider, the poll retry limit and the settle time in clock cycles are parameters.

Top module: `fpga_cfg_seq`

## Requirements
- R1: The SPI bus runs in mode 0. `sclk_o` idles low, each half period lasts CLK_DIV clock cycles, MOSI sends the MSB first and changes only while `sclk_o` is low, and MISO is sampled on the rising edge of `sclk_o`.
- R2: A status poll consists of two single-byte transactions, each sending 0x00, with `cs_no` high between them. Only the byte received in the second transaction is evaluated.
- R3: In the evaluated status byte, bit 0 means busy, bit 1 ready, bit 2 bus violation and bit 3 bus error. If bit 2 or bit 3 is set, the session aborts with kind 2 (device error).
- R4: A poll repeats while busy is set. A poll that needs ready also repeats until ready is set. After POLL_LIMIT polls without success the session aborts with kind 1 (timeout).
- R5: Opening the session takes these steps in order: a not-busy poll, the transaction {0x0B}, a ready poll, and one transaction that sends 0x01 and then reads four bytes while sending 0x00. If any of the four bytes is nonzero, the session aborts with kind 3 in phase 1.
- R6: Program mode is entered by a not-busy poll followed by the transaction {0xAE, 0x01}.
- R7: For each of the `frame_count_i` frames, a not-busy poll is followed by one transaction holding 0xEE and then 16 stream bytes in arrival order. A count of zero sends no frames.
- R8: Closing takes these steps: a not-busy poll and {0x0C}, then `cs_no` held high for at least SETTLE_CYCLES cycles, then a not-busy poll and {0x23}. After that, `done_o`=1 and `error_o`=0.
- R9: `bs_ready_o` is high only while a frame data byte is awaited. A byte is taken on a cycle where `bs_valid_i` and `bs_ready_o` are both high.
- R10: Any failure raises `cs_no` and sets `done_o`=1 and `error_o`=1. `err_phase_o` is 1 for open, 2 for program, 3 for frame, 4 for close and 5 for release, and `err_kind_o` gives the cause.
- R11: After reset the block is idle with `cs_no`=1, `sclk_o`=0, `done_o`=0, `error_o`=0 and `bs_ready_o`=0. `start_i` in the idle or finished state begins a new session and clears `done_o` and the error outputs on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a session (idle or finished state only) |
| frame_count_i | input | FCW | Number of 16-byte frames, sampled at start |
| bs_data_i | input | 8 | Bitstream byte |
| bs_valid_i | input | 1 | Bitstream byte valid |
| bs_ready_o | output | 1 | Bitstream byte accepted when valid is also high |
| done_o | output | 1 | Session finished (held until next start) |
| error_o | output | 1 | Session ended in failure |
| err_phase_o | output | 3 | Failing phase code |
| err_kind_o | output | 2 | Failure cause: 1 timeout, 2 device error, 3 bad result |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to device |
| miso_i | input | 1 | SPI data from device |

## Verification
The hardest situations to reach are a device fault or a timeout that strikes at one particular gate deep in the session, such as the poll before the second frame or before release. They are also hard to tell apart, because the first read of each status pair always returns a garbage byte with the error bits set. The bench's device model counts status pairs and injects a fault byte on a chosen pair index. It holds busy for a chosen number of pairs, and it withholds ready for a chosen number of pairs after the open command. This steers each abort into a known phase and makes the total poll count predictable. Random sessions vary the frame count, the busy and ready delays, and the gaps in the byte stream.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;
  localparam logic [7:0] OP_STATUS   = 8'h00;
  localparam logic [7:0] OP_RDDATA   = 8'h01;
  localparam logic [7:0] OP_OPEN     = 8'h0B;
  localparam logic [7:0] OP_CLOSE    = 8'h0C;
  localparam logic [7:0] OP_PRG_INIT = 8'hAE;
  localparam logic [7:0] OP_PRG_ARG  = 8'h01;
  localparam logic [7:0] OP_FRAME    = 8'hEE;
  localparam logic [7:0] OP_RELEASE  = 8'h23;

  localparam int FRAME_BYTES  = 16;
  localparam int RESULT_BYTES = 4;

  localparam int SB_BUSY  = 0;
  localparam int SB_READY = 1;
  localparam int SB_VIOL  = 2;
  localparam int SB_ERR   = 3;

  typedef enum logic [2:0] {
    ST_OPEN_CMD, ST_OPEN_RD, ST_PROG, ST_FRAME, ST_CLOSE, ST_REL
  } step_e;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0, EK_TIMEOUT = 2'd1, EK_DEVICE = 2'd2, EK_RESULT = 2'd3
  } err_kind_e;

  function automatic logic [2:0] step_phase(step_e s);
    case (s)
      ST_OPEN_CMD, ST_OPEN_RD: return 3'd1;
      ST_PROG:                 return 3'd2;
      ST_FRAME:                return 3'd3;
      ST_CLOSE:                return 3'd4;
      default:                 return 3'd5;
    endcase
  endfunction

  function automatic logic [4:0] step_len(step_e s);
    case (s)
      ST_OPEN_RD: return 5'(1 + RESULT_BYTES);
      ST_PROG:    return 5'd2;
      ST_FRAME:   return 5'(1 + FRAME_BYTES);
      default:    return 5'd1;
    endcase
  endfunction

  function automatic logic [7:0] step_byte(step_e s, logic [4:0] idx);
    case (s)
      ST_OPEN_CMD: return OP_OPEN;
      ST_OPEN_RD:  return (idx == 5'd0) ? OP_RDDATA : OP_STATUS;
      ST_PROG:     return (idx == 5'd0) ? OP_PRG_INIT : OP_PRG_ARG;
      ST_FRAME:    return OP_FRAME;
      ST_CLOSE:    return OP_CLOSE;
      default:     return OP_RELEASE;
    endcase
  endfunction
endpackage

// File: rtl/cfg_spi_shift.sv
`timescale 1ns/1ps
module cfg_spi_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          busy_q, sclk_q, done_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0; bit_q <= '0; busy_q <= 1'b0; sclk_q <= 1'b0;
      done_q <= 1'b0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1; tx_q <= tx_i; div_q <= '0; bit_q <= '0; sclk_q <= 1'b0;
        end
      end else if (div_q == DW'(CLK_DIV - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            tx_q  <= {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_q[7];

  // R1: data line frozen while the clock is high
  a_r1_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(mosi_o));
  // R1: a byte always ends with the clock back low
  a_r1_done_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !sclk_o);
endmodule

// File: rtl/cfg_settle_timer.sv
`timescale 1ns/1ps
module cfg_settle_timer #(
  parameter int CYCLES = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt_q;
  logic          run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1; cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q == TW'(CYCLES - 1)) begin
          run_q <= 1'b0; done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  assign done_o = done_q;

  // R8: count never passes the programmed settle length
  a_r8_settle_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < TW'(CYCLES)));
endmodule

// File: rtl/fpga_cfg_seq.sv
`timescale 1ns/1ps
module fpga_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int POLL_LIMIT    = 10000,
  parameter int SETTLE_CYCLES = 200000,
  parameter int FCW           = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [FCW-1:0] frame_count_i,
  input  logic [7:0]     bs_data_i,
  input  logic           bs_valid_i,
  output logic           bs_ready_o,
  output logic           done_o,
  output logic           error_o,
  output logic [2:0]     err_phase_o,
  output logic [1:0]     err_kind_o,
  output logic           sclk_o,
  output logic           cs_no,
  output logic           mosi_o,
  input  logic           miso_i
);
  localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL1, S_PGAP, S_POLL2, S_CGAP, S_CMD, S_SETTLE, S_DONE
  } state_e;

  state_e         state_q;
  step_e          step_q;
  logic [4:0]     idx_q;
  logic [FCW-1:0] frames_q;
  logic [PCW-1:0] poll_q;
  logic           inflight_q, to_cmd_q, res_nz_q, done_q, err_q;
  logic [2:0]     eph_q;
  logic [1:0]     ekind_q;

  logic       sh_start, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       tmr_start, tmr_done;
  logic       in_poll, need_data, need_ready, last_byte;
  logic       st_fault, st_wait;

  assign in_poll    = (state_q == S_POLL1) || (state_q == S_POLL2);
  assign need_data  = (step_q == ST_FRAME) && (idx_q != 5'd0);
  assign need_ready = (step_q == ST_OPEN_RD);
  assign last_byte  = (idx_q == step_len(step_q) - 5'd1);
  assign st_fault   = sh_rx[SB_VIOL] | sh_rx[SB_ERR];
  assign st_wait    = sh_rx[SB_BUSY] | (need_ready & ~sh_rx[SB_READY]);

  assign sh_start = !inflight_q &&
                    (in_poll || ((state_q == S_CMD) && (!need_data || bs_valid_i)));
  assign sh_tx    = in_poll ? OP_STATUS : (need_data ? bs_data_i : step_byte(step_q, idx_q));
  assign tmr_start = (state_q == S_CMD) && sh_done && last_byte && (step_q == ST_CLOSE);

  assign bs_ready_o  = (state_q == S_CMD) && need_data && !inflight_q;
  assign cs_no       = !(in_poll || (state_q == S_CMD));
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign err_phase_o = eph_q;
  assign err_kind_o  = ekind_q;

  cfg_spi_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i, .rst_ni, .start_i(sh_start), .tx_i(sh_tx), .done_o(sh_done),
    .rx_o(sh_rx), .sclk_o, .mosi_o, .miso_i
  );

  cfg_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i, .rst_ni, .start_i(tmr_start), .done_o(tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           inflight_q <= 1'b0;
    else if (sh_start)     inflight_q <= 1'b1;
    else if (sh_done)      inflight_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; step_q <= ST_OPEN_CMD; idx_q <= '0; frames_q <= '0;
      poll_q <= '0; to_cmd_q <= 1'b0; res_nz_q <= 1'b0; done_q <= 1'b0;
      err_q <= 1'b0; eph_q <= '0; ekind_q <= EK_NONE;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: if (start_i) begin
          state_q <= S_POLL1; step_q <= ST_OPEN_CMD; frames_q <= frame_count_i;
          poll_q <= '0; done_q <= 1'b0; err_q <= 1'b0; eph_q <= '0; ekind_q <= EK_NONE;
        end
        S_POLL1: if (sh_done) state_q <= S_PGAP;
        S_PGAP:  state_q <= S_POLL2;
        S_POLL2: if (sh_done) begin
          if (st_fault) begin
            state_q <= S_DONE; done_q <= 1'b1; err_q <= 1'b1;
            eph_q <= step_phase(step_q); ekind_q <= EK_DEVICE;
          end else if (st_wait) begin
            if (poll_q == PCW'(POLL_LIMIT - 1)) begin
              state_q <= S_DONE; done_q <= 1'b1; err_q <= 1'b1;
              eph_q <= step_phase(step_q); ekind_q <= EK_TIMEOUT;
            end else begin
              poll_q <= poll_q + PCW'(1); to_cmd_q <= 1'b0; state_q <= S_CGAP;
            end
          end else begin
            poll_q <= '0; to_cmd_q <= 1'b1; idx_q <= '0; res_nz_q <= 1'b0;
            state_q <= S_CGAP;
          end
        end
        S_CGAP: state_q <= to_cmd_q ? S_CMD : S_POLL1;
        S_CMD: if (sh_done) begin
          if ((step_q == ST_OPEN_RD) && (idx_q != 5'd0) && (sh_rx != 8'h00)) res_nz_q <= 1'b1;
          if (!last_byte) begin
            idx_q <= idx_q + 5'd1;
          end else begin
            to_cmd_q <= 1'b0;
            state_q  <= S_CGAP;
            case (step_q)
              ST_OPEN_CMD: step_q <= ST_OPEN_RD;
              ST_OPEN_RD: begin
                if (res_nz_q || (sh_rx != 8'h00)) begin
                  state_q <= S_DONE; done_q <= 1'b1; err_q <= 1'b1;
                  eph_q <= step_phase(step_q); ekind_q <= EK_RESULT;
                end else begin
                  step_q <= ST_PROG;
                end
              end
              ST_PROG: step_q <= (frames_q == '0) ? ST_CLOSE : ST_FRAME;
              ST_FRAME: begin
                frames_q <= frames_q - FCW'(1);
                if (frames_q == FCW'(1)) step_q <= ST_CLOSE;
              end
              ST_CLOSE: begin
                state_q <= S_SETTLE; step_q <= ST_REL;
              end
              default: begin
                state_q <= S_DONE; done_q <= 1'b1;
              end
            endcase
          end
        end
        S_SETTLE: if (tmr_done) state_q <= S_POLL1;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // R1 / R10: no clock activity outside a selected transaction
  a_r1_sclk_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R9: stream accepted only inside a frame transaction
  a_r9_ready_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_ready_o |-> !cs_no);
  // R10: an error always comes with done and a phase/kind code
  a_r10_error_coded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (done_o && (err_kind_o != 2'd0) && (err_phase_o != 3'd0)));
  // R4: retry counter stays inside the limit
  a_r4_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q <= PCW'(POLL_LIMIT - 1));
  // R11: finished block leaves the bus and stream idle
  a_r11_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !bs_ready_o));
  // R2: the second status read starts after chip select was high
  a_r2_pair_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL2 && $past(state_q) != S_POLL2) |-> $past(cs_no));
endmodule

// File: tb/sim_fpga_cfg_seq.sv
`timescale 1ns/1ps
module sim_fpga_cfg_seq;
  localparam int DIV = 2;
  localparam int LIM = 8;
  localparam int SET = 40;
  localparam int FW  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic start_i = 1'b0;
  logic [FW-1:0] frame_count_i = '0;
  logic [7:0] bs_data_i = '0;
  logic bs_valid_i = 1'b0;
  logic bs_ready_o, done_o, error_o, sclk_o, cs_no, mosi_o;
  logic [2:0] err_phase_o;
  logic [1:0] err_kind_o;
  logic miso = 1'b0;

  always #2.5 clk = ~clk;

  fpga_cfg_seq #(.CLK_DIV(DIV), .POLL_LIMIT(LIM), .SETTLE_CYCLES(SET), .FCW(FW)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .frame_count_i, .bs_data_i, .bs_valid_i, .bs_ready_o,
    .done_o, .error_o, .err_phase_o, .err_kind_o, .sclk_o, .cs_no, .mosi_o, .miso_i(miso)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model configuration
  int busy_left = 0, ready_cfg = 0, ready_wait = 0, err_pair = -1, pair_idx = 0, pairs = 0;
  logic [7:0] err_val = 8'h00;
  logic [7:0] res [4];
  bit half = 1'b0;
  int stat_kind = 0;

  // transaction capture
  logic [7:0] tb_bytes [32];
  int bi = 0, bc = 0;
  logic [7:0] rxs = 8'h00, txb = 8'h00;
  bit reload = 1'b0;
  logic [7:0] clog [2048];
  int cstart [128];
  int clen [128];
  int ncmd = 0, clog_n = 0;
  int dis_end = 0, gap = -1;
  bit after_dis = 1'b0;

  always @(negedge cs_no) if (rst_ni) begin
    bi = 0; bc = 0; reload = 1'b0; stat_kind = 0;
    if (half) begin
      if (pair_idx == err_pair)  begin txb = err_val; stat_kind = 3; end
      else if (busy_left > 0)    begin txb = 8'h01;   stat_kind = 1; end
      else if (ready_wait > 0)   begin txb = 8'h00;   stat_kind = 2; end
      else                             txb = 8'h02;
    end else begin
      txb = 8'h0D;  // first read of a pair is never trusted
    end
    miso = txb[7];
    if (after_dis) begin gap = cyc - dis_end; after_dis = 1'b0; end
  end

  always @(posedge sclk_o) if (!cs_no) begin
    rxs = {rxs[6:0], mosi_o};
    bc++;
    if (bc == 8) begin
      tb_bytes[bi] = rxs;
      bi++; bc = 0;
      txb = (bi <= 4) ? res[bi-1] : 8'h00;
      reload = 1'b1;
    end
  end

  always @(negedge sclk_o) if (!cs_no) begin
    if (reload) reload = 1'b0;
    else txb = {txb[6:0], 1'b0};
    miso = txb[7];
  end

  always @(posedge cs_no) if (rst_ni && bi > 0) begin
    if (bi == 1 && tb_bytes[0] == 8'h00) begin
      if (half) begin
        pairs++; pair_idx++;
        if (stat_kind == 1) busy_left--;
        else if (stat_kind == 2) ready_wait--;
      end
      half = !half;
    end else begin
      cstart[ncmd] = clog_n; clen[ncmd] = bi;
      for (int i = 0; i < bi; i++) begin clog[clog_n] = tb_bytes[i]; clog_n++; end
      ncmd++;
      if (tb_bytes[0] == 8'h0B) ready_wait = ready_cfg;
      if (tb_bytes[0] == 8'h0C) begin dis_end = cyc; after_dis = 1'b1; end
    end
  end

  // SCLK half-period monitor (R1)
  int hi_run = 0, bad_hi = 0;
  always @(posedge clk) begin
    if (sclk_o) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run != DIV) bad_hi++;
      hi_run = 0;
    end
  end

  // bitstream source
  logic [7:0] dat [128];
  int hs_cnt = 0, ready_idle = 0;
  always @(posedge clk) begin
    if (bs_valid_i && bs_ready_o) hs_cnt++;
    if (bs_ready_o && cs_no) ready_idle++;
  end
  always @(negedge clk) begin
    bs_valid_i = ($urandom % 4) != 0;
    bs_data_i  = dat[hs_cnt];
  end

  // expected command stream
  logic [7:0] eb [2048];
  int es [128];
  int el [128];
  int en = 0, eb_n = 0;
  task automatic push_cmd(input logic [7:0] b0, input int len, input int fbase, input int kind);
    es[en] = eb_n; el[en] = len;
    eb[eb_n] = b0; eb_n++;
    for (int i = 1; i < len; i++) begin
      if (kind == 1) eb[eb_n] = 8'h00;
      else if (kind == 2) eb[eb_n] = 8'h01;
      else eb[eb_n] = dat[fbase + i - 1];
      eb_n++;
    end
    en++;
  endtask

  function automatic string cmd_tag(input int k, input int n);
    if (k < 2) return "R5 open sequence";
    if (k == 2) return "R6 program mode";
    if (k < 3 + n) return "R7 frame content";
    return "R8 close/release";
  endfunction

  task automatic session(input int n, input int b, input int r, input int ep,
                         input logic [7:0] ev, input logic [31:0] rw,
                         input int ek, input int eph, input int exp_pairs);
    int k;
    bit ok;
    busy_left = b; ready_cfg = r; ready_wait = 0; err_pair = ep; err_val = ev;
    pair_idx = 0; pairs = 0; half = 1'b0;
    res[0] = rw[31:24]; res[1] = rw[23:16]; res[2] = rw[15:8]; res[3] = rw[7:0];
    for (int i = 0; i < 128; i++) dat[i] = 8'($urandom);
    hs_cnt = 0; ready_idle = 0; ncmd = 0; clog_n = 0; gap = -1; after_dis = 1'b0; bad_hi = 0;
    en = 0; eb_n = 0;
    push_cmd(8'h0B, 1, 0, 0);
    push_cmd(8'h01, 5, 0, 1);
    push_cmd(8'hAE, 2, 0, 2);
    for (int f = 0; f < n; f++) push_cmd(8'hEE, 17, f * 16, 0);
    push_cmd(8'h0C, 1, 0, 0);
    push_cmd(8'h23, 1, 0, 0);

    @(negedge clk); frame_count_i = FW'(n); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(done_o == 1'b0 && error_o == 1'b0, "R11 start clears done", int'(done_o), 0);
    k = 0;
    while (!done_o && k < 30000) begin @(negedge clk); k++; end
    chk(k < 30000, "R10 session ends (watchdog)", k, 30000);
    repeat (3) @(negedge clk);
    chk(int'(error_o) == (ek != 0), "R10 error flag", int'(error_o), int'(ek != 0));
    chk(int'(err_kind_o) == ek, "R3/R4/R5 error kind", int'(err_kind_o), ek);
    chk(int'(err_phase_o) == eph, "R10 error phase", int'(err_phase_o), eph);
    chk(cs_no == 1'b1 && bs_ready_o == 1'b0, "R10 bus released", int'(cs_no), 1);
    chk(ready_idle == 0, "R9 no ready outside transaction", ready_idle, 0);
    chk(bad_hi == 0, "R1 sclk half period", bad_hi, 0);
    if (exp_pairs >= 0) chk(pairs == exp_pairs, "R2/R4 status pair count", pairs, exp_pairs);
    if (ek == 0) begin
      chk(ncmd == en, "R7/R8 command count", ncmd, en);
      for (int c = 0; c < en && c < ncmd; c++) begin
        ok = (clen[c] == el[c]);
        for (int i = 0; i < el[c] && ok; i++) ok = (clog[cstart[c] + i] == eb[es[c] + i]);
        chk(ok, cmd_tag(c, n), int'(clog[cstart[c]]), int'(eb[es[c]]));
      end
      chk(hs_cnt == 16 * n, "R9 bytes taken", hs_cnt, 16 * n);
      chk(gap >= SET && gap <= SET + 10, "R8 settle gap", gap, SET);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    res[0] = 0; res[1] = 0; res[2] = 0; res[3] = 0;
    #2 rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_no == 1'b1 && sclk_o == 1'b0, "R11 reset bus idle", int'(cs_no), 1);
    chk(done_o == 1'b0 && error_o == 1'b0 && bs_ready_o == 1'b0, "R11 reset flags", int'(done_o), 0);

    session(2, 0, 0, -1, 8'h00, 32'h0, 0, 0, 7);          // R7 two frames
    session(0, 0, 0, -1, 8'h00, 32'h0, 0, 0, 5);          // R7 zero frames
    session(3, 3, 2, -1, 8'h00, 32'h0, 0, 0, 13);         // R4 busy and ready delays
    session(1, 100, 0, -1, 8'h00, 32'h0, 1, 1, LIM);      // R4 busy timeout
    session(1, 0, 100, -1, 8'h00, 32'h0, 1, 1, 1 + LIM);  // R4 ready never set
    session(1, 0, 0, 2, 8'h08, 32'h0, 2, 2, -1);          // R3 error bit in program phase
    session(1, 0, 0, 0, 8'h04, 32'h0, 2, 1, -1);          // R3 violation bit in open phase
    session(1, 0, 0, -1, 8'h00, 32'h0000_4000, 3, 1, -1); // R5 nonzero result
    session(2, 0, 0, 4, 8'h08, 32'h0, 2, 3, -1);          // R10 abort at second frame
    session(1, 0, 0, 4, 8'h0C, 32'h0, 2, 4, -1);          // R10 abort at close
    session(1, 0, 0, 5, 8'h04, 32'h0, 2, 5, -1);          // R10 abort at release
    for (int s = 0; s < 6; s++) begin
      int n, b, r;
      n = $urandom % 5; b = $urandom % 6; r = $urandom % 4;
      session(n, b, r, -1, 8'h00, 32'h0, 0, 0, n + 5 + b + r);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule